// File: doc/BRIEF.md
# Dual-Mode Parallel Host Bus Register Slave

This block lets an external processor reach the registers of a chip over an 8-bit asynchronous parallel bus. A static strap selects one of two signalling styles. In the Intel-style mode, a latch-enable strobe carries the address and separate active-low read and write strobes start each cycle. In the Motorola-style mode, an address strobe carries the address, a data strobe frames the cycle and a level on a direction pin says whether it is a read or a write. The same three pins serve both styles. In both modes, chip select is active low and gates every access.

Every host strobe is synchronized into the system clock before any edge is acted on. A 15-bit address is captured from the address pins when the synchronized address-strobe edge is seen. Each accepted cycle becomes a single-cycle pulse on an internal register port: address, write data, write enable, read enable, and read data that returns a fixed number of clocks later. The block then raises a handshake that tells the host the cycle is done. For a read, the bidirectional data bus is driven through an output enable while the host holds the read strobe, and it is released as soon as that strobe returns high.

Top module: `hostBusSlave`

## Requirements
- R1: Input `modeMoto` selects the bus style: 1 is Motorola-style and 0 is Intel-style. It is changed only while reset is held.
- R2: The address pins are captured into `regAddr`. In Motorola mode this happens on a rising edge of `aleAs`; in Intel mode it happens on a falling edge of `aleAs`. The address must stay stable for at least three clocks after that edge. Address changes outside that window do not alter `regAddr`.
- R3: `csN` is active low. While `csN` is high, no strobe produces `regWe` or `regRe`, the handshake stays inactive and the data bus is not driven.
- R4: In Motorola mode a cycle starts when `csN` and `rdDs` are both low. At that time, `wrRw` high marks a read and `wrRw` low marks a write.
- R5: In Intel mode a cycle starts when `csN` is low and either `rdDs` or `wrRw` is low. `rdDs` low marks a read and `wrRw` low marks a write.
- R6: A write produces exactly one clock of `regWe`, with `regAddr` at the captured address and `regWdata` at the value on the data bus. The handshake turns active on the clock that follows the `regWe` pulse.
- R7: A read produces exactly one clock of `regRe`. The block captures `regRdata` `RD_LAT` clocks later, and the captured byte is on the data bus when the handshake turns active.
- R8: The data bus is driven only during a read cycle while `csN` and `rdDs` are both low. It returns to high impedance within one clock of `rdDs` going high.
- R9: The handshake pin `rdyAck` is active low in Motorola mode and active high in Intel mode. After reset it is inactive, `regWe` and `regRe` are low and the data bus is not driven.
- R10: The handshake goes inactive within three clocks after the cycle strobe or `csN` is released. A new cycle is not accepted until `csN` and all cycle strobes have returned inactive together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeMoto | input | 1 | Bus style strap: 1 Motorola-style, 0 Intel-style |
| csN | input | 1 | Chip select, active low |
| aleAs | input | 1 | Address latch enable (Intel) or address strobe (Motorola) |
| rdDs | input | 1 | Read strobe (Intel) or data strobe (Motorola), active low |
| wrRw | input | 1 | Write strobe (Intel) or read/write direction, 1 is read (Motorola) |
| addrIn | input | ADDR_W | Host address pins |
| dataIo | inout | DATA_W | Bidirectional host data bus |
| rdyAck | output | 1 | Cycle handshake: ready (Intel, high) or acknowledge (Motorola, low) |
| regAddr | output | ADDR_W | Register port address |
| regWdata | output | DATA_W | Register port write data |
| regWe | output | 1 | Register port write enable, one clock |
| regRe | output | 1 | Register port read enable, one clock |
| regRdata | input | DATA_W | Register port read data, valid RD_LAT clocks after regRe |

## Verification
The assertions assume the host behaves as a well-behaved bus master. It holds the address for three clocks after the capturing edge, sets the direction level before lowering the data strobe, and keeps write data on the bus until it sees the handshake. They also assume the mode strap moves only during reset. The stimulus follows these rules in every access. It drives a decoy address on the opposite strobe edge and after the hold window, and it changes the mode only inside a reset pulse. Before each new cycle it releases chip select and the strobes together, except in the test that deliberately holds chip select low to probe the re-arm rule.

// File: rtl/hbPkg.sv
package hbPkg;

  // Cycle sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRPULSE,
    ST_RDWAIT,
    ST_ACK,
    ST_RELEASE
  } hbState_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic capAddr;      // latch the address pins this clock
    logic startWrite;   // issue write enable next clock
    logic startRead;    // issue read enable next clock
    logic readCapture;  // register port read data is valid now
    logic readCycle;    // current cycle is a read
  } hbStrobe_t;

endpackage

// File: rtl/hbSync.sv
module hbSync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= {STAGES{RESET_VAL}};
    end else begin
      for (int i = STAGES - 1; i > 0; i--) begin
        stageQ[i] <= stageQ[i-1];
      end
      stageQ[0] <= asyncIn;
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/hbCtrl.sv
module hbCtrl
  import hbPkg::*;
#(
  parameter int RD_LAT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeMoto,
  input  logic       csSync,
  input  logic       aleSync,
  input  logic       rdSync,
  input  logic       wrSync,
  output hbStrobe_t  strobes,
  output logic       ackOn
);

  localparam int CNT_W = $clog2(RD_LAT + 1);
  localparam logic [CNT_W-1:0] LAT_LAST = CNT_W'(RD_LAT);

  hbState_t state, stateNext;
  logic alePrev;
  logic [CNT_W-1:0] latCnt;
  logic isRdQ;
  logic csAct, strobeAct, wantRead, aleEdge, startOk;

  // Mode-specific pin decode
  always_comb begin
    csAct = ~csSync;
    if (modeMoto) begin
      strobeAct = ~rdSync;
      wantRead  = wrSync;
      aleEdge   = aleSync & ~alePrev;
    end else begin
      strobeAct = ~rdSync | ~wrSync;
      wantRead  = ~rdSync;
      aleEdge   = ~aleSync & alePrev;
    end
  end

  assign startOk = (state == ST_IDLE) && csAct && strobeAct;

  always_comb begin
    strobes.capAddr     = aleEdge;
    strobes.startRead   = startOk & wantRead;
    strobes.startWrite  = startOk & ~wantRead;
    strobes.readCapture = (state == ST_RDWAIT) && (latCnt == LAT_LAST);
    strobes.readCycle   = isRdQ;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (startOk) stateNext = wantRead ? ST_RDWAIT : ST_WRPULSE;
      end
      ST_WRPULSE: stateNext = ST_ACK;
      ST_RDWAIT: begin
        if (latCnt == LAT_LAST) stateNext = ST_ACK;
      end
      ST_ACK: begin
        if (!(csAct && strobeAct)) stateNext = ST_RELEASE;
      end
      ST_RELEASE: begin
        if (!csAct && !strobeAct) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      alePrev <= 1'b1;
      latCnt  <= '0;
      isRdQ   <= 1'b0;
    end else begin
      state   <= stateNext;
      alePrev <= aleSync;
      if (state == ST_RDWAIT) latCnt <= latCnt + 1'b1;
      else                    latCnt <= '0;
      if (strobes.startRead)       isRdQ <= 1'b1;
      else if (strobes.startWrite) isRdQ <= 1'b0;
      else if (state == ST_RELEASE && stateNext == ST_IDLE) isRdQ <= 1'b0;
    end
  end

  assign ackOn = (state == ST_ACK);

  // R10
  ackDrop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackOn && !(csAct && strobeAct) |=> !ackOn);

  // R10
  singleStart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.startRead || strobes.startWrite) |=> !(strobes.startRead || strobes.startWrite));

  // R7
  captureThenAck_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.readCapture |=> ackOn);

endmodule

// File: rtl/hbDatapath.sv
module hbDatapath
  import hbPkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  hbStrobe_t         strobes,
  input  logic              csPinN,
  input  logic              rdPinN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] regRdata,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  output logic              regRe,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdHoldQ;
  logic weQ, reQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      rdHoldQ <= '0;
      weQ     <= 1'b0;
      reQ     <= 1'b0;
    end else begin
      if (strobes.capAddr)     addrQ   <= addrIn;
      if (strobes.startWrite)  wdataQ  <= dataIn;
      if (strobes.readCapture) rdHoldQ <= regRdata;
      weQ <= strobes.startWrite;
      reQ <= strobes.startRead;
    end
  end

  assign regAddr  = addrQ;
  assign regWdata = wdataQ;
  assign regWe    = weQ;
  assign regRe    = reQ;
  assign busOut   = rdHoldQ;
  // Pad enable follows the raw pins so release needs no clock
  assign busOe    = strobes.readCycle & ~csPinN & ~rdPinN;

  // R6
  wePulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  // R7
  rePulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRe |=> !regRe);

  // R8
  noDriveOnWrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> !busOe);

endmodule

// File: rtl/hostBusSlave.sv
module hostBusSlave
  import hbPkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int RD_LAT = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeMoto,
  input  logic              csN,
  input  logic              aleAs,
  input  logic              rdDs,
  input  logic              wrRw,
  input  logic [ADDR_W-1:0] addrIn,
  inout  wire  [DATA_W-1:0] dataIo,
  output logic              rdyAck,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  output logic              regRe,
  input  logic [DATA_W-1:0] regRdata
);

  localparam int PIN_N = 4;

  logic [PIN_N-1:0] pinSync;
  hbStrobe_t strobes;
  logic ackOn;
  logic [DATA_W-1:0] busOut;
  logic busOe;

  hbSync #(
    .WIDTH(PIN_N),
    .STAGES(SYNC_STAGES),
    .RESET_VAL('1)
  ) uSync (
    .clk(clk),
    .rstN(rstN),
    .asyncIn({csN, aleAs, rdDs, wrRw}),
    .syncOut(pinSync)
  );

  hbCtrl #(
    .RD_LAT(RD_LAT)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .modeMoto(modeMoto),
    .csSync(pinSync[3]),
    .aleSync(pinSync[2]),
    .rdSync(pinSync[1]),
    .wrSync(pinSync[0]),
    .strobes(strobes),
    .ackOn(ackOn)
  );

  hbDatapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uPath (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .csPinN(csN),
    .rdPinN(rdDs),
    .addrIn(addrIn),
    .dataIn(dataIo),
    .regRdata(regRdata),
    .regAddr(regAddr),
    .regWdata(regWdata),
    .regWe(regWe),
    .regRe(regRe),
    .busOut(busOut),
    .busOe(busOe)
  );

  assign dataIo = busOe ? busOut : 'z;
  // Acknowledge polarity per bus style
  assign rdyAck = modeMoto ? ~ackOn : ackOn;

  // R6
  weThenAck_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> ackOn);

endmodule

// File: tb/sim_hostBusSlave.sv
`timescale 1ns/1ps
module sim_hostBusSlave;

  localparam int RD_LAT = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeMoto = 1'b1;
  logic csN = 1'b1, aleAs = 1'b1, rdDs = 1'b1, wrRw = 1'b1;
  logic [14:0] addrIn = '0;
  logic hostDrive = 1'b0;
  logic [7:0] hostData = '0;
  wire  [7:0] dataIo;
  logic rdyAck;
  logic [14:0] regAddr;
  logic [7:0] regWdata, regRdata;
  logic regWe, regRe;

  always #2.5 clk = ~clk;

  assign dataIo = hostDrive ? hostData : 'z;
  for (genvar b = 0; b < 8; b++) begin : gPull
    pullup (dataIo[b]);
  end

  hostBusSlave #(.RD_LAT(RD_LAT)) u0 (
    .clk(clk), .rstN(rstN), .modeMoto(modeMoto), .csN(csN), .aleAs(aleAs),
    .rdDs(rdDs), .wrRw(wrRw), .addrIn(addrIn), .dataIo(dataIo), .rdyAck(rdyAck),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRe(regRe),
    .regRdata(regRdata)
  );

  // Register file model behind the port
  logic [7:0] mem [256];
  logic [7:0] pipe [RD_LAT];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i ^ 8'h5A) & 8'h7F;
      for (int i = 0; i < RD_LAT; i++) pipe[i] <= '0;
    end else begin
      if (regWe) mem[regAddr[7:0]] <= regWdata;
      pipe[0] <= regRe ? mem[regAddr[7:0]] : 8'h00;
      for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
    end
  end
  assign regRdata = pipe[RD_LAT-1];

  // Port monitor
  bit curMoto = 1'b1;
  int cyc = 0, weCount = 0, reCount = 0, weRun = 0, weRunMax = 0;
  int weCyc = 0, ackCyc = 0;
  bit prevAck = 1'b0;
  logic [14:0] lastWeAddr = '0, lastReAddr = '0;
  logic [7:0] lastWeData = '0;

  function automatic bit ackAct();
    return curMoto ? !rdyAck : rdyAck;
  endfunction

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (regWe) begin
      weCount <= weCount + 1; lastWeAddr <= regAddr; lastWeData <= regWdata;
      weCyc <= cyc; weRun <= weRun + 1;
      if (weRun + 1 > weRunMax) weRunMax <= weRun + 1;
    end else weRun <= 0;
    if (regRe) begin reCount <= reCount + 1; lastReAddr <= regAddr; end
    if (rstN && ackAct() && !prevAck) ackCyc <= cyc;
    prevAck <= ackAct();
  end

  int vectors = 0, fails = 0;
  bit finished = 1'b0;
  logic [7:0] expMem [256];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // Full host cycle: address phase, data phase, release
  task automatic access(input bit wr, input logic [14:0] a, input logic [7:0] d,
                        output logic [7:0] q, output bit gotAck,
                        output logic [7:0] busAfter, output bit ackAfter);
    addrIn = ~a;
    aleAs = curMoto ? 1'b0 : 1'b1;   // decoy address on the non-capturing edge
    repeat (2) @(negedge clk);
    addrIn = a;
    repeat (2) @(negedge clk);
    aleAs = curMoto ? 1'b1 : 1'b0;   // capturing edge
    repeat (5) @(negedge clk);
    addrIn = ~a;                     // decoy after the hold window
    csN = 1'b0;
    if (wr) begin hostData = d; hostDrive = 1'b1; end
    if (curMoto) begin
      wrRw = wr ? 1'b0 : 1'b1;
      @(negedge clk);
      rdDs = 1'b0;
    end else begin
      @(negedge clk);
      if (wr) wrRw = 1'b0; else rdDs = 1'b0;
    end
    gotAck = 1'b0;
    for (int t = 0; t < 40 && !gotAck; t++) begin
      @(negedge clk);
      if (ackAct()) gotAck = 1'b1;
    end
    q = dataIo;
    rdDs = 1'b1; wrRw = 1'b1; hostDrive = 1'b0; csN = 1'b1;
    @(negedge clk);
    busAfter = dataIo;
    repeat (3) @(negedge clk);
    ackAfter = ackAct();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    endRun();
  end

  initial begin
    logic [7:0] q, busAfter;
    bit gotAck, ackAfter;
    int weBefore, reBefore;
    for (int m = 0; m < 2; m++) begin
      // R1: strap changes only inside reset
      rstN = 1'b0;
      curMoto = (m == 0);
      modeMoto = curMoto;
      aleAs = curMoto ? 1'b1 : 1'b0;
      csN = 1'b1; rdDs = 1'b1; wrRw = 1'b1; hostDrive = 1'b0;
      for (int i = 0; i < 256; i++) expMem[i] = 8'(i ^ 8'h5A) & 8'h7F;
      repeat (4) @(negedge clk);
      // R9 reset state
      chk(!ackAct(), "R9 ack inactive in reset", rdyAck, curMoto);
      chk(!regWe && !regRe, "R9 port idle in reset", {regWe, regRe}, 0);
      chk(dataIo == 8'hFF, "R9 bus released in reset", dataIo, 8'hFF);
      rstN = 1'b1;
      repeat (6) @(negedge clk);

      // Write sweep (R2, R4, R5, R6, R10)
      for (int i = 0; i < 24; i++) begin
        logic [14:0] a;
        logic [7:0] d;
        a = (i == 23) ? 15'h7FFF : 15'((i * 1237 + i * i * 97) & 32'h7FFF);
        d = 8'((a[7:0] * 3 + 8'h11 + m) & 8'h7F);
        weBefore = weCount;
        access(1'b1, a, d, q, gotAck, busAfter, ackAfter);
        expMem[a[7:0]] = d;
        chk(gotAck, curMoto ? "R4 write ack" : "R5 write ready", gotAck, 1);
        chk(weCount == weBefore + 1, "R6 one write pulse", weCount - weBefore, 1);
        chk(lastWeAddr == a, "R2 write address", lastWeAddr, a);
        chk(lastWeData == d, "R6 write data", lastWeData, d);
        chk(ackCyc == weCyc + 1, "R6 ack follows pulse", ackCyc - weCyc, 1);
        chk(!ackAfter, "R10 ack released", ackAfter, 0);
      end

      // Read sweep (R2, R4, R5, R7, R8, R10)
      for (int i = 0; i < 24; i++) begin
        logic [14:0] a;
        a = (i == 23) ? 15'h7FFF : 15'((i * 1237 + i * i * 97) & 32'h7FFF);
        reBefore = reCount;
        access(1'b0, a, 8'h00, q, gotAck, busAfter, ackAfter);
        chk(gotAck, curMoto ? "R4 read ack" : "R5 read ready", gotAck, 1);
        chk(reCount == reBefore + 1, "R7 one read pulse", reCount - reBefore, 1);
        chk(lastReAddr == a, "R2 read address", lastReAddr, a);
        chk(q == expMem[a[7:0]], "R7 read data", q, expMem[a[7:0]]);
        chk(busAfter == 8'hFF, "R8 bus released", busAfter, 8'hFF);
        chk(!ackAfter, "R10 ack released", ackAfter, 0);
      end
      // A few unwritten locations
      for (int i = 0; i < 6; i++) begin
        logic [14:0] a;
        a = 15'(16'h4100 + i * 16'h0013);
        access(1'b0, a, 8'h00, q, gotAck, busAfter, ackAfter);
        chk(q == expMem[a[7:0]], "R7 read default", q, expMem[a[7:0]]);
      end

      // R3: strobes ignored while chip select is high
      weBefore = weCount; reBefore = reCount;
      rdDs = 1'b0;
      repeat (12) @(negedge clk);
      chk(!ackAct(), "R3 no ack without cs", ackAct(), 0);
      chk(dataIo == 8'hFF, "R3 bus not driven", dataIo, 8'hFF);
      rdDs = 1'b1; wrRw = 1'b0;
      if (curMoto) begin @(negedge clk); rdDs = 1'b0; end
      repeat (12) @(negedge clk);
      chk(weCount == weBefore && reCount == reBefore, "R3 no port access",
          weCount + reCount, weBefore + reBefore);
      rdDs = 1'b1; wrRw = 1'b1;
      repeat (6) @(negedge clk);

      // R10: no restart while chip select stays low
      reBefore = reCount;
      csN = 1'b0; wrRw = 1'b1;
      @(negedge clk);
      rdDs = 1'b0;
      for (int t = 0; t < 40 && !ackAct(); t++) @(negedge clk);
      rdDs = 1'b1;
      repeat (6) @(negedge clk);
      chk(!ackAct(), "R10 ack drops on strobe release", ackAct(), 0);
      rdDs = 1'b0;
      repeat (15) @(negedge clk);
      chk(reCount == reBefore + 1, "R10 no restart", reCount - reBefore, 1);
      chk(!ackAct(), "R10 no ack on restart", ackAct(), 0);
      rdDs = 1'b1; csN = 1'b1;
      repeat (6) @(negedge clk);
      access(1'b0, 15'h0042, 8'h00, q, gotAck, busAfter, ackAfter);
      chk(gotAck && q == expMem[8'h42], "R10 re-armed", q, expMem[8'h42]);
    end
    chk(weRunMax == 1, "R6 write pulse width", weRunMax, 1);
    endRun();
  end

endmodule